// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block turns a fast transfer clock into the serial clock of an SPI host and marks each clock transition for the shift engine. The divide ratio has two parts: a linear field `n` (0..255) and a power-of-two exponent `N` (0..3). The serial bit rate is f_clk / (2·(n+1)·2^N). The fastest setting is f_clk/2 (n=0, N=0), so a 200 MHz transfer clock gives 100 MHz. The slowest is f_clk/4096 (n=255, N=3).

Each half period lasts (n+1)·2^N clock cycles. A prescaler of 2^N drives a modulo-(n+1) counter. While the enable is low, both counters sit at zero and SCK rests at the idle polarity. A rising enable starts a transfer. At that moment the block captures the divider fields and the polarity, and the first SCK edge comes one full half period later. Two one-cycle strobes line up with the SCK transitions: a leading strobe marks the edge away from idle, and a trailing strobe marks the return to idle.

Top module: `spi_rate_gen`

## Requirements
- R1: Under reset, sck_o, lead_o and trail_o are all 0.
- R2: In any cycle that follows a clock edge where en_i was low, sck_o equals the cpol_i value seen at that edge, and lead_o and trail_o are both 0.
- R3: Let H = (n+1)·2^N, where n = lin_div_i and N = exp_div_i. Take as edge 0 the first rising clock edge at which en_i is high after being low. Then sck_o changes only at edges k·H (k ≥ 1), and inverts at each of them.
- R4: lead_o is 1 for exactly the one cycle after each edge at which sck_o moves away from the captured polarity, and is 0 at all other times.
- R5: trail_o is 1 for exactly the one cycle after each edge at which sck_o returns to the captured polarity, and is 0 at all other times.
- R6: lin_div_i, exp_div_i and cpol_i are captured only at edge 0. Changing them during a transfer leaves the running timing and polarity unchanged.
- R7: Dropping en_i for a single cycle in the middle of a half period and raising it again restarts the phase from zero, with the first edge a full H cycles after the new edge 0.
- R8: With n=0 and N=0, sck_o inverts at every edge. With n=255 and N=3, the half period is 2048 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transfer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transfer enable; a rising level starts a transfer |
| cpol_i | input | 1 | Idle level of SCK |
| lin_div_i | input | LIN_W | Linear divider field n |
| exp_div_i | input | EXP_W | Exponent field N (prescale 2^N) |
| sck_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe on the transition away from idle |
| trail_o | output | 1 | One-cycle strobe on the transition back to idle |

## Verification
The bench uses the default widths (LIN_W=8, EXP_W=2). It sweeps every exponent against linear values 0 through 7, so every prescale ratio is exercised combined with every small modulus. Each of these runs uses both idle polarities. The extreme setting n=255, N=3 is run as well, which checks the full 2048-cycle half period and the widest counter values. Directed runs change the fields in the middle of a transfer and pulse the enable low partway through a half period.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  localparam int unsigned LIN_W_DEF = 8;
  localparam int unsigned EXP_W_DEF = 2;

  // prescaler counter width: enough for 2^(2^EXP_W - 1) - 1
  function automatic int unsigned pre_width(input int unsigned exp_w);
    return (1 << exp_w) - 1;
  endfunction
endpackage

// File: rtl/spi_rate_prescale.sv
module spi_rate_prescale
  import spi_rate_pkg::*;
#(
  parameter int unsigned EXP_W = EXP_W_DEF,
  localparam int unsigned CW = pre_width(EXP_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  logic [CW-1:0] cnt_q, lim;

  always_comb begin
    for (int i = 0; i < CW; i++) lim[i] = (i < int'(exp_i));
  end

  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q == lim) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  p_pre_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
  p_pre_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/spi_rate_modcnt.sv
module spi_rate_modcnt
  import spi_rate_pkg::*;
#(
  parameter int unsigned LIN_W = LIN_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [LIN_W-1:0] lim_i,
  output logic             wrap_o
);
  logic [LIN_W-1:0] cnt_q;

  assign wrap_o = tick_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  p_mod_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= lim_i);
endmodule

// File: rtl/spi_rate_edge.sv
module spi_rate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  input  logic cpol_i,
  input  logic cpol_lat_i,
  input  logic wrap_i,
  output logic sck_o,
  output logic lead_o,
  output logic trail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_o   <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!en_i || !run_i) begin
      // idle and start edge: park at requested polarity
      sck_o   <= cpol_i;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (wrap_i) begin
      sck_o   <= ~sck_o;
      lead_o  <= (sck_o == cpol_lat_i);
      trail_o <= (sck_o != cpol_lat_i);
    end else begin
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end
  end

  p_idle_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sck_o == $past(cpol_i)) && !lead_o && !trail_o);
  p_lead_away_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sck_o != cpol_lat_i) && (sck_o != $past(sck_o)));
  p_trail_back_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sck_o == cpol_lat_i) && (sck_o != $past(sck_o)));
  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_pkg::*;
#(
  parameter int unsigned LIN_W = LIN_W_DEF,
  parameter int unsigned EXP_W = EXP_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cpol_i,
  input  logic [LIN_W-1:0] lin_div_i,
  input  logic [EXP_W-1:0] exp_div_i,
  output logic             sck_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic             run_q, cpol_q;
  logic [LIN_W-1:0] lin_q;
  logic [EXP_W-1:0] exp_q;
  logic             tick, wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cpol_q <= 1'b0;
      lin_q  <= '0;
      exp_q  <= '0;
    end else begin
      run_q <= en_i;
      if (en_i && !run_q) begin
        cpol_q <= cpol_i;
        lin_q  <= lin_div_i;
        exp_q  <= exp_div_i;
      end
    end
  end

  spi_rate_prescale #(.EXP_W(EXP_W)) u_pre (
    .clk_i, .rst_ni, .run_i(run_q), .exp_i(exp_q), .tick_o(tick)
  );

  spi_rate_modcnt #(.LIN_W(LIN_W)) u_mod (
    .clk_i, .rst_ni, .run_i(run_q), .tick_i(tick), .lim_i(lin_q), .wrap_o(wrap)
  );

  spi_rate_edge u_edge (
    .clk_i, .rst_ni, .en_i, .run_i(run_q), .cpol_i, .cpol_lat_i(cpol_q),
    .wrap_i(wrap), .sck_o, .lead_o, .trail_o
  );

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && en_i |=> $stable(lin_q) && $stable(exp_q) && $stable(cpol_q));
  p_toggle_marked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && en_i |=> (sck_o != $past(sck_o)) == (lead_o || trail_o));
endmodule

// File: tb/spi_rate_gen_test.sv
module spi_rate_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cpol = 1'b0;
  logic [7:0] lin = '0;
  logic [1:0] expo = '0;
  logic sck, lead, trail;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_rate_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol),
    .lin_div_i(lin), .exp_div_i(expo),
    .sck_o(sck), .lead_o(lead), .trail_o(trail)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: {sck,lead,trail} act=%b exp=%b", req, act, exp_v);
    end
  endtask

  // idle_n negedges of idle, then a run of len cycles; optionally disturb fields at k==1
  task automatic run_cfg(input int n, input int ex, input logic pol, input int len,
                         input int idle_n, input bit disturb, input string req);
    int h = (n + 1) * (1 << ex);
    en = 1'b0;
    cpol = pol;
    lin = 8'(n);
    expo = 2'(ex);
    for (int i = 0; i < idle_n; i++) begin
      @(negedge clk);
      chk("R2", {sck, lead, trail}, {pol, 2'b00});
    end
    en = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      begin
        logic es, el, et;
        es = pol ^ ((k / h) % 2 == 1);
        el = (k > 0) && (k % h == 0) && ((k / h) % 2 == 1);
        et = (k > 0) && (k % h == 0) && ((k / h) % 2 == 0);
        chk(req, {sck, lead, trail}, {es, el, et});
      end
      if (disturb && k == 1) begin
        lin = 8'(n + 3);
        expo = 2'(ex + 1);
        cpol = ~pol;
      end
    end
  endtask

  initial begin
    #3;
    chk("R1", {sck, lead, trail}, 3'b000);
    #20;
    chk("R1", {sck, lead, trail}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    // R3 R4 R5 sweep of small configurations
    for (int ex = 0; ex < 4; ex++)
      for (int n = 0; n < 8; n++)
        for (int p = 0; p < 2; p++)
          run_cfg(n, ex, p[0], 4 * (n + 1) * (1 << ex) + 2, 2, 1'b0, "R3/R4/R5");
    // R8 extremes
    run_cfg(0, 0, 1'b0, 12, 2, 1'b0, "R8");
    run_cfg(255, 3, 1'b1, 2 * 2048 + 3, 2, 1'b0, "R8");
    run_cfg(255, 0, 1'b0, 2 * 256 + 3, 2, 1'b0, "R8");
    // R6 mid-run field change ignored
    run_cfg(1, 0, 1'b0, 20, 2, 1'b1, "R6");
    run_cfg(2, 1, 1'b1, 30, 2, 1'b1, "R6");
    // R7 restart mid half-period after one idle cycle
    run_cfg(2, 0, 1'b0, 5, 2, 1'b0, "R7");
    run_cfg(2, 0, 1'b0, 14, 1, 1'b0, "R7");
    run_cfg(3, 1, 1'b1, 11, 2, 1'b0, "R7");
    run_cfg(3, 1, 1'b1, 20, 1, 1'b0, "R7");
    en = 1'b0;
    @(negedge clk);
    chk("R2", {sck, lead, trail}, {cpol, 2'b00});
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: act=timeout exp=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule